// File: doc/BRIEF.md
# Interrupt Status Register with Mailbox Flags

This block is a single 32-bit interrupt status word that a local processor reads and clears over a plain register port with one address match. It gathers three kinds of information: a sticky flag that records a low-to-high transition of an external active-low interrupt line (only when the host-bridge mode input is high), eight sticky flags that record writes into eight host-to-local mailbox registers, and six read-only bits that mirror chosen bits of an external configuration status word.

Sticky flags are cleared by writing 1 to their bit positions. If a set event arrives in the same cycle as the clear, the set wins. A registered interrupt output is raised when any sticky flag is set and its bit is enabled in a mask input.

Top module: `irq_status_reg`

## Requirements
- R1: With `host_mode` high, a 0-to-1 change on `hint_n` sets bit 7. The input is registered once and compared with its previous sample, so bit 7 reads 1 after the second rising clock edge following the change.
- R2: A write of 1 to bit 7 at the register address clears bit 7 at the next edge, unless a detected rise of `hint_n` falls in that same cycle. In that case bit 7 stays 1.
- R3: With `host_mode` low, bit 7 reads 0 and does not set. It is also cleared at the next edge.
- R4: Bits 13:8 are read-only copies of `cfg_status` bits 8, 11, 12, 13, 14 and 15, in that order from bit 8 upward.
- R5: Bus writes do not change bits 13:8.
- R6: A high `mbox_wr[n]` sets bit 16+n (n = 0..7) at the next edge.
- R7: Writing 1 to bit 16+n at the register address clears that flag at the next edge, unless `mbox_wr[n]` is high in the same cycle. Writes to any other address have no effect.
- R8: Bits 14, 15 and 31:24 always read 0. When `bus_addr` does not match the register address, `rdata` is 0.
- R9: `irq` goes high one edge after a state in which any sticky flag (bit 7 or 23:16) is set with the matching `irq_en` bit high. Otherwise it goes low.
- R10: While `rst` is high at an edge, all sticky flags and `irq` clear. The previous sample of `hint_n` is taken as 1, so reset alone cannot create an edge.
- R11: `rdata` is combinational from the current flags. In a clearing write cycle it still shows the flag values from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | Enables the interrupt-line edge flag |
| hint_n | input | 1 | Active-low interrupt line that is monitored for rises |
| cfg_status | input | 16 | External configuration status word |
| mbox_wr | input | 8 | One write strobe per mailbox |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 32 | Write data; ones clear sticky flags |
| rdata | output | 32 | Read data for a matching address, else 0 |
| irq_en | input | 32 | Per-bit enable mask for the interrupt output |
| irq | output | 1 | Registered interrupt to the processor |

## Verification
A lost or stuck flag shows on `rdata` in the first cycle after the edge where the flag should have changed. A wrong value in the edge-detect history shows up as a missing or false bit 7 two edges after the line changes. An error in the interrupt combination appears on `irq` one cycle later again. The bench's reference model updates at every edge and is compared with both outputs in every cycle, so any of these errors is reported within one to two cycles of its cause.

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_mode,
  input  logic              hint_n,
  input  logic [15:0]       cfg_status,
  input  logic [7:0]        mbox_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       rdata,
  input  logic [31:0]       irq_en,
  output logic              irq
);
  logic       line_s, line_p;
  logic       edge_q;
  logic [7:0] mbx_q;

  wire hit  = bus_addr == REG_ADDR;
  wire clr  = hit && bus_wr;
  wire rise = line_s && !line_p;
  wire [5:0] mirror = {cfg_status[15:11], cfg_status[8]};

  always_ff @(posedge clk) begin
    if (rst) begin
      line_s <= 1'b1;
      line_p <= 1'b1;
      edge_q <= 1'b0;
      mbx_q  <= '0;
      irq    <= 1'b0;
    end else begin
      line_s <= hint_n;
      line_p <= line_s;
      edge_q <= host_mode && (rise || (edge_q && !(clr && bus_wdata[7])));
      mbx_q  <= mbox_wr | (mbx_q & ~({8{clr}} & bus_wdata[23:16]));
      irq    <= (edge_q && irq_en[7]) || |(mbx_q & irq_en[23:16]);
    end
  end

  assign rdata = hit ? {8'h00, mbx_q, 2'b00, mirror, edge_q, 7'h00} : 32'h0;
endmodule

module irq_status_reg_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h040
) (
  input logic              clk,
  input logic              rst,
  input logic              host_mode,
  input logic [7:0]        mbox_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              irq,
  input logic              edge_q,
  input logic [7:0]        mbx_q
);
  a_r6_mbox_sets: assert property (@(posedge clk) disable iff (rst)
    (mbox_wr != 8'h00) |=> ((mbx_q & $past(mbox_wr)) == $past(mbox_wr)));

  a_r3_mode_off: assert property (@(posedge clk) disable iff (rst)
    !host_mode |=> !edge_q);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!(bus_wr && bus_addr == REG_ADDR) && mbox_wr == 8'h00) |=> $stable(mbx_q));

  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    (mbx_q == 8'h00 && !edge_q) |=> !irq);

  a_r10_reset: assert property (@(posedge clk)
    rst |=> (mbx_q == 8'h00 && !edge_q && !irq));
endmodule

bind irq_status_reg irq_status_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst(rst), .host_mode(host_mode), .mbox_wr(mbox_wr),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .irq(irq), .edge_q(edge_q), .mbx_q(mbx_q)
);

// File: tb/tb_irq_status_reg.sv
module tb_irq_status_reg;
  localparam logic [11:0] RA = 12'h040;
  logic clk = 0, rst = 1, host_mode = 0, hint_n = 1, bus_wr = 0, irq;
  logic [15:0] cfg_status = 0;
  logic [7:0]  mbox_wr = 0;
  logic [11:0] bus_addr = RA;
  logic [31:0] bus_wdata = 0, irq_en = 0, rdata;
  int n_cmp = 0, n_bad = 0;
  string req = "R10";

  always #10 clk = ~clk;

  irq_status_reg dut (.*);

  bit m_s = 1, m_p = 1, m_f7 = 0, m_irq = 0;
  bit [7:0] m_mbx = 0;

  always @(posedge clk) begin
    bit rise, hitw;
    rise = m_s && !m_p;
    hitw = bus_wr && bus_addr == RA;
    if (rst) begin
      m_s = 1; m_p = 1; m_f7 = 0; m_mbx = 0; m_irq = 0;
    end else begin
      m_irq = (m_f7 && irq_en[7]);
      for (int i = 0; i < 8; i++) if (m_mbx[i] && irq_en[16+i]) m_irq = 1;
      m_f7 = host_mode && (rise || (m_f7 && !(hitw && bus_wdata[7])));
      for (int i = 0; i < 8; i++)
        m_mbx[i] = mbox_wr[i] || (m_mbx[i] && !(hitw && bus_wdata[16+i]));
      m_p = m_s; m_s = hint_n;
    end
  end

  function automatic logic [31:0] exp_rd();
    logic [31:0] v = 0;
    if (bus_addr != RA) return 0;
    v[7] = m_f7;
    v[8] = cfg_status[8];
    for (int k = 0; k < 5; k++) v[9+k] = cfg_status[11+k];
    v[23:16] = m_mbx;
    return v;
  endfunction

  task automatic cmp();
    n_cmp++;
    if (rdata !== exp_rd()) begin
      n_bad++;
      $display("FAIL %s rdata actual=%h expected=%h", req, rdata, exp_rd());
    end
    n_cmp++;
    if (irq !== m_irq) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq, m_irq);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #4; cmp();
    end
  endtask

  task automatic expect_bit(string r, int b, bit v);
    n_cmp++;
    if (rdata[b] !== v) begin
      n_bad++;
      $display("FAIL %s bit%0d actual=%b expected=%b", r, b, rdata[b], v);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 0; host_mode = 1;
    req = "R10"; cyc(4);
    expect_bit("R10", 7, 0);

    req = "R1"; hint_n = 0; cyc(3); hint_n = 1; cyc(1);
    expect_bit("R1", 7, 0); cyc(1); expect_bit("R1", 7, 1); cyc(2);

    req = "R11"; bus_wr = 1; bus_wdata = 32'h80; #1;
    expect_bit("R11", 7, 1); cyc(1); bus_wr = 0; expect_bit("R11", 7, 0); cyc(1);

    req = "R2"; hint_n = 0; cyc(3); hint_n = 1; cyc(1);
    bus_wr = 1; bus_wdata = 32'h80; cyc(1); bus_wr = 0;
    expect_bit("R2", 7, 1); cyc(2);

    req = "R9"; irq_en = 32'h80; cyc(2);
    irq_en = 0; cyc(2);

    req = "R3"; host_mode = 0; cyc(1); expect_bit("R3", 7, 0);
    hint_n = 0; cyc(3); hint_n = 1; cyc(4); expect_bit("R3", 7, 0);
    host_mode = 1; cyc(2);

    req = "R4";
    for (int b = 0; b < 16; b++) begin cfg_status = 16'(1 << b); cyc(1); end
    cfg_status = 16'hA5C3; cyc(1);

    req = "R5"; bus_wr = 1; bus_wdata = 32'hFFFF_FFFF; cyc(1);
    cfg_status = 16'hFFFF; cyc(1); bus_wr = 0; cyc(1);

    req = "R8"; expect_bit("R8", 14, 0); expect_bit("R8", 31, 0);
    bus_addr = 12'h044; cyc(1); bus_addr = RA; cyc(1);

    req = "R6";
    for (int m = 0; m < 8; m++) begin mbox_wr = 8'(1 << m); cyc(1); end
    mbox_wr = 0; cyc(1); expect_bit("R6", 23, 1);

    req = "R7"; bus_addr = 12'h048; bus_wr = 1; bus_wdata = 32'hFFFF_FFFF; cyc(1);
    bus_addr = RA; bus_wdata = 32'h00F0_0000; cyc(1);
    bus_wdata = 32'h000F_0000; mbox_wr = 8'h01; cyc(1);
    bus_wr = 0; mbox_wr = 0; expect_bit("R7", 16, 1); expect_bit("R7", 17, 0);

    req = "R9"; irq_en = 32'h0001_0000; cyc(3);
    irq_en = 32'h0002_0000; cyc(3);
    bus_wr = 1; bus_wdata = 32'h00FF_0080; cyc(1); bus_wr = 0;
    irq_en = 32'hFFFF_FFFF; cyc(3);

    req = "R10"; mbox_wr = 8'hFF; cyc(1); mbox_wr = 0; rst = 1; cyc(2);
    rst = 0; cyc(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule